// File: doc/BRIEF.md
# I2C Master STOP Sequencer with Arbitration-Loss Detection

This block produces the STOP condition at the end of an I2C master transfer and watches the bus for another master while it does so. It controls the open-drain SDA and SCL lines through drive-low enables and reads both lines back through a synchroniser. A pulse on the request input starts the sequence. The block holds both lines low, then lets SCL rise and waits until SCL is really high, so slow devices can stretch the clock. It then times a hold phase, releases SDA, and times a settle phase before it checks the result.

A down-counter loaded from a 7-bit reload value times each phase. The block has two ways to lose the bus during the STOP. In the first, SCL reads low during the hold phase while SDA is still driven low. In the second, SDA still reads low at the end of the settle phase. In either case the block releases both lines, returns to idle and sets a sticky collision flag. A STOP that completes gives a one-cycle done pulse instead.

Top module: `i2c_stop_seq`

## Requirements
- R1: After a synchronous reset, both drive-low enables are 0, and busy, done and collision are 0.
- R2: A request accepted in idle sets both the SDA and SCL drive-low enables to 1 in the same cycle. SCL is released only after the synchronised SDA reads low, and SDA stays driven while SCL is released.
- R3: After SCL is released, the block waits for the synchronised SCL to read high before it starts the hold phase. An external device can hold SCL low for any length of time without causing a collision. With no stretching, SCL is released and SDA driven for 3 + L cycles, where L is the effective reload value. Each cycle of stretching adds one cycle.
- R4: At the end of the hold phase, SDA is released while SCL is already released. The settle phase lasts L + 2 cycles, where 2 is the synchroniser depth. With no collision, done pulses high for exactly one cycle in the cycle after busy falls.
- R5: A reload value of 0 behaves exactly like a reload value of 1.
- R6: If the synchronised SDA reads low at the end of the settle phase, collision is set and done stays 0.
- R7: If the synchronised SCL reads low at any point in the hold phase, collision is set at once and done stays 0.
- R8: When a collision is detected, both enables go to 0 and busy goes to 0 in the same cycle that collision rises.
- R9: Collision stays set until a clear pulse arrives. While it is set, a request is ignored: busy and the SDA enable stay 0.
- R10: A request that arrives while a sequence is running is ignored, so a sequence gives exactly one done pulse.
- R11: Done is never high while busy is high, and never in the same cycle that collision rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | One-cycle pulse that requests a STOP |
| reload | input | 7 | Phase length in clocks (0 is treated as 1) |
| clr_coll | input | 1 | Write-one-to-clear pulse for the collision flag |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| done | output | 1 | One-cycle pulse on successful STOP |
| coll | output | 1 | Sticky bus-collision flag |
| busy | output | 1 | STOP sequence in progress |

## Verification
The hardest case to reach is an SCL collision during the hold phase. It only counts if the external pull-down comes after the synchronised SCL has already been seen high. A pull-down any earlier is legal clock stretching. The bench drives a wired-AND model of each line. It counts the cycles in which SCL is released and SDA is still driven, and it asserts the external SCL pull only after that count has passed the release-and-synchronise latency, so the pull lands inside a long hold phase. The same cycle count shows the clock-stretch case apart, because each extra low cycle adds exactly one cycle to the released-SCL window.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SDA_LOW = 3'd1,
    ST_SCL_REL = 3'd2,
    ST_HOLD    = 3'd3,
    ST_SETTLE  = 3'd4
  } stop_state_e;
endpackage

// File: rtl/i2c_stop_sync.sv
module i2c_stop_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '1;
          else     pipe[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '1;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_stop_brg.sv
module i2c_stop_brg #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          tick
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == CW'(1));

  // R5: an idle counter never wraps or restarts on its own
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq #(
  parameter int RW          = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stop_req,
  input  logic [RW-1:0] reload,
  input  logic          clr_coll,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          done,
  output logic          coll,
  output logic          busy
);
  import i2c_stop_pkg::*;

  localparam int CW = RW + 2;

  stop_state_e   st, nxt;
  logic [1:0]    lines_s;
  logic          scl_s, sda_s;
  logic          brg_load, tick;
  logic [CW-1:0] brg_val, ph_hold, ph_settle;
  logic          set_coll, fin;
  logic          sda_oe_q, scl_oe_q, done_q, coll_q, busy_q;

  i2c_stop_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2c_stop_brg #(.CW(CW)) u_brg (
    .clk(clk), .rst(rst), .load(brg_load), .load_val(brg_val), .tick(tick)
  );

  assign ph_hold   = (reload == '0) ? CW'(1) : CW'(reload);
  assign ph_settle = ph_hold + CW'(SYNC_STAGES);

  always_comb begin
    nxt      = st;
    brg_load = 1'b0;
    brg_val  = ph_hold;
    set_coll = 1'b0;
    fin      = 1'b0;
    case (st)
      ST_IDLE:    if (stop_req && !coll_q) nxt = ST_SDA_LOW;
      ST_SDA_LOW: if (!sda_s) nxt = ST_SCL_REL;
      ST_SCL_REL: if (scl_s) begin
        nxt      = ST_HOLD;
        brg_load = 1'b1;
        brg_val  = ph_hold;
      end
      ST_HOLD: begin
        if (!scl_s) begin
          set_coll = 1'b1;
          nxt      = ST_IDLE;
        end else if (tick) begin
          nxt      = ST_SETTLE;
          brg_load = 1'b1;
          brg_val  = ph_settle;
        end
      end
      ST_SETTLE: if (tick) begin
        nxt = ST_IDLE;
        if (!sda_s) set_coll = 1'b1;
        else        fin      = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      sda_oe_q <= 1'b0;
      scl_oe_q <= 1'b0;
      done_q   <= 1'b0;
      busy_q   <= 1'b0;
      coll_q   <= 1'b0;
    end else begin
      st       <= nxt;
      sda_oe_q <= (nxt == ST_SDA_LOW) || (nxt == ST_SCL_REL) || (nxt == ST_HOLD);
      scl_oe_q <= (nxt == ST_SDA_LOW);
      done_q   <= fin;
      busy_q   <= (nxt != ST_IDLE);
      if (set_coll)      coll_q <= 1'b1;
      else if (clr_coll) coll_q <= 1'b0;
    end
  end

  assign sda_oe = sda_oe_q;
  assign scl_oe = scl_oe_q;
  assign done   = done_q;
  assign coll   = coll_q;
  assign busy   = busy_q;

  // R2: SCL pull-down starts together with SDA and ends while SDA is held
  a_r2_scl_rise_with_sda: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe_q) |-> sda_oe_q);
  a_r2_scl_free_sda_held: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_oe_q) |-> sda_oe_q);
  // R4: SDA is let go only with SCL already free
  a_r4_sda_after_scl: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe_q) |-> !scl_oe_q);
  // R8: abort releases the bus
  a_r8_abort_release: assert property (@(posedge clk) disable iff (rst)
    $rose(coll_q) |-> (!sda_oe_q && !scl_oe_q && !busy_q));
  // R9: flag is sticky and blocks requests
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (coll_q && !clr_coll) |=> coll_q);
  a_r9_req_blocked: assert property (@(posedge clk) disable iff (rst)
    (coll_q && !busy_q) |=> !busy_q);
  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R11: done excludes busy and a fresh collision
  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  a_r11_done_no_coll: assert property (@(posedge clk) disable iff (rst)
    $rose(coll_q) |-> !done_q);
endmodule

// File: tb/i2c_stop_seq_bench.sv
module i2c_stop_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stop_req = 1'b0;
  logic [6:0] reload = '0;
  logic       clr_coll = 1'b0;
  logic       ext_scl = 1'b0;
  logic       ext_sda = 1'b0;
  logic       scl_oe, sda_oe, done, coll, busy;
  logic       scl_line, sda_line;
  int         vectors = 0;
  int         miss = 0;

  always #10 clk = ~clk;

  assign scl_line = !(scl_oe || ext_scl);
  assign sda_line = !(sda_oe || ext_sda);

  i2c_stop_seq u_i2c_stop_seq (
    .clk(clk), .rst(rst), .stop_req(stop_req), .reload(reload),
    .clr_coll(clr_coll), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .coll(coll), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one STOP. a = cycles with SCL free and SDA driven; b = cycles with SDA free and busy.
  task automatic run_stop(input int rl, input int stretch, input int scl_pull_at,
                          input bit sda_pull, output int a, output int b,
                          output bit got_done);
    a = 0; b = 0; got_done = 0;
    @(negedge clk);
    reload = 7'(rl); stop_req = 1'b1; ext_scl = (stretch > 0);
    @(negedge clk);
    stop_req = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (done) begin got_done = 1; break; end
      if (!busy) break;
      if (!scl_oe && sda_oe) begin
        a++;
        if (stretch > 0 && a == stretch) ext_scl = 1'b0;
        if (scl_pull_at > 0 && a == scl_pull_at) ext_scl = 1'b1;
        if (sda_pull && a == 1) ext_sda = 1'b1;
      end
      if (!sda_oe && busy) b++;
      @(negedge clk);
    end
    ext_scl = 1'b0;
    ext_sda = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 coll", int'(coll), 0);
    chk("R1 done", int'(done), 0);
  endtask

  task automatic t_first_edge;
    @(negedge clk);
    reload = 7'd4; stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk("R2 sda driven first", int'(sda_oe), 1);
    chk("R2 scl held low", int'(scl_oe), 1);
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_normal(input int rl, input int eff);
    int a, b; bit d;
    run_stop(rl, 0, 0, 0, a, b, d);
    chk("R3 hold window", a, 3 + eff);
    chk("R4 settle window", b, eff + 2);
    chk("R4 done seen", int'(d), 1);
    chk("R11 busy low at done", int'(busy), 0);
    chk("R11 no coll", int'(coll), 0);
    @(negedge clk);
    chk("R4 done one cycle", int'(done), 0);
  endtask

  task automatic t_stretch;
    int a, b; bit d;
    run_stop(5, 10, 0, 0, a, b, d);
    chk("R3 stretched window", a, 12 + 5);
    chk("R3 stretch no coll", int'(coll), 0);
    chk("R3 stretch done", int'(d), 1);
    @(negedge clk);
  endtask

  task automatic t_sda_coll;
    int a, b; bit d;
    run_stop(6, 0, 0, 1, a, b, d);
    chk("R6 coll set", int'(coll), 1);
    chk("R6 no done", int'(d), 0);
    chk("R8 sda released", int'(sda_oe), 0);
    chk("R8 scl released", int'(scl_oe), 0);
    chk("R8 idle", int'(busy), 0);
  endtask

  task automatic t_blocked_and_clear;
    @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    repeat (4) begin
      chk("R9 req ignored busy", int'(busy), 0);
      chk("R9 req ignored sda", int'(sda_oe), 0);
      @(negedge clk);
    end
    chk("R9 still set", int'(coll), 1);
    clr_coll = 1'b1;
    @(negedge clk);
    clr_coll = 1'b0;
    chk("R9 cleared", int'(coll), 0);
  endtask

  task automatic t_scl_coll;
    int a, b; bit d;
    run_stop(20, 0, 8, 0, a, b, d);
    chk("R7 coll set", int'(coll), 1);
    chk("R7 no done", int'(d), 0);
    chk("R7 sda never released early", b, 0);
    chk("R8 both released", int'(sda_oe | scl_oe), 0);
    clr_coll = 1'b1;
    @(negedge clk);
    clr_coll = 1'b0;
  endtask

  task automatic t_busy_req;
    int dones = 0;
    @(negedge clk);
    reload = 7'd5; stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    repeat (5) @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done) dones++;
      @(negedge clk);
    end
    chk("R10 single done", dones, 1);
    chk("R10 idle after", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miss++;
    vectors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_edge();
    t_normal(4, 4);
    t_normal(0, 1);   // R5: zero reload acts as one
    t_normal(1, 1);   // R5: reference for the zero case
    t_stretch();
    t_sda_coll();
    t_blocked_and_clear();
    t_scl_coll();
    t_busy_req();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule